// File: doc/BRIEF.md
# DS3 C-bit Format Qualifier

This block sits behind a DS3 receive framer and turns two per-frame fields into stable status. For every M-frame the framer presents a strobe together with the sampled application-identification bit and the three far-end block error bits. The block decides whether the line is really carrying the C-bit parity format, and it keeps a copy of the latest far-end error code for software to read.

The format indication uses asymmetric hysteresis. It sets only after a long unbroken run of frames with the identification bit at 1. It clears when too many zeros appear inside a short sliding window of recent frames. A one-cycle pulse marks each change of the indication so that an interrupt stage can pick it up. Strobes that arrive while the framer reports loss of alignment are dropped, and all state is held until alignment returns.

Top module: `cbit_fmt_qual`

## Requirements
- R1: `fmt_cbit` rises only on the accepted frame that completes 63 consecutive accepted frames with `aic_in`=1. It stays low after 62 such frames.
- R2: Any accepted frame with `aic_in`=0 restarts the consecutive-ones count from zero. The count saturates at 63.
- R3: While `fmt_cbit` is 1, it clears on the accepted frame that leaves 2 or more zeros among the 15 most recent accepted frames, the current frame included. A single zero in that window leaves it set.
- R4: A zero that is 16 or more accepted frames old no longer counts towards R3.
- R5: `febe_stat` equals the `febe_in` value of the most recently accepted frame, whatever its value. The code 3'b111 means the far end has no errors. The code 3'b011 means the far end saw framing or parity errors.
- R6: `fmt_cbit`, `febe_stat` and `fmt_chg` all update on the clock edge that accepts a frame, where a frame is accepted when `frm_stb` and `in_sync` are both 1.
- R7: `fmt_chg` is 1 for exactly one cycle after each transition of `fmt_cbit`, in either direction, and 0 in every other cycle.
- R8: A strobe seen while `in_sync`=0 is ignored. The run count, the history, `fmt_cbit` and `febe_stat` keep their values.
- R9: An active-low reset clears `fmt_cbit`, `fmt_chg`, the run count and the history, and loads `febe_stat` with 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | One pulse per received M-frame |
| in_sync | input | 1 | Framer alignment flag; strobes are accepted only while it is 1 |
| aic_in | input | 1 | Application-identification bit of the current frame |
| febe_in | input | 3 | Far-end block error bits of the current frame |
| fmt_cbit | output | 1 | Qualified C-bit parity format indication |
| febe_stat | output | 3 | Latched far-end block error code |
| fmt_chg | output | 1 | One-cycle pulse on each change of `fmt_cbit` |

## Verification
Every result is due in the cycle that directly follows the edge accepting a frame: the indication, the FEBE copy and the change pulse are each one register away from the inputs. The scoreboard's driver predicts these three values when it issues a frame. The monitor waits for the accepting rising edge and compares them at the next falling edge. In every cycle without an accepted frame, the monitor checks that the change pulse is low. After dropped out-of-sync strobes, the bench reads the held outputs directly, away from any edge.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

  // Number of set bits in a word; callers zero-extend narrower vectors.
  function automatic int unsigned cbq_popcount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

  // Next value of a saturating run counter.
  function automatic int unsigned cbq_run_step(input int unsigned cur,
                                               input logic one,
                                               input int unsigned lim);
    if (!one)
      return 0;
    else if (cur >= lim)
      return lim;
    else
      return cur + 1;
  endfunction

endpackage

// File: rtl/cbq_run_counter.sv
module cbq_run_counter
  import cbq_pkg::*;
#(
  parameter int unsigned RUN_LIM = 63,
  localparam int unsigned RW = $clog2(RUN_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          bit_one,
  output logic [RW-1:0] run_q,
  output logic [RW-1:0] run_next
);

  int unsigned step_val;

  always_comb begin
    step_val = cbq_run_step(int'(run_q), bit_one, RUN_LIM);
    run_next = accept ? step_val[RW-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_next;
  end

  // R2: a zero frame restarts the run
  p_run_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bit_one) |=> (run_q == '0));

  // R2: the counter never passes its limit
  p_run_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= RUN_LIM);

  // R8: nothing moves without an accepted frame
  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(run_q));

endmodule

// File: rtl/cbq_zero_window.sv
module cbq_zero_window
  import cbq_pkg::*;
#(
  parameter int unsigned WIN = 15,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          bit_one,
  output logic [CW-1:0] zeros_now,
  output logic [CW-1:0] zeros_next
);

  // A 1 in the history marks a frame whose bit was 0.
  logic [WIN-1:0] hist_q;
  logic [WIN-1:0] hist_d;
  int unsigned    cnt_now;
  int unsigned    cnt_next;

  generate
    if (WIN > 1) begin : g_shift
      assign hist_d = accept ? {hist_q[WIN-2:0], ~bit_one} : hist_q;
    end else begin : g_single
      assign hist_d = accept ? ~bit_one : hist_q;
    end
  endgenerate

  always_comb begin
    cnt_now    = cbq_popcount(32'(hist_q));
    cnt_next   = cbq_popcount(32'(hist_d));
    zeros_now  = cnt_now[CW-1:0];
    zeros_next = cnt_next[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R8: the window is frozen between accepted frames
  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(hist_q));

  // R3: a zero frame always leaves at least one mark in the window
  p_zero_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bit_one) |=> (zeros_now != '0));

endmodule

// File: rtl/cbq_febe_hold.sv
module cbq_febe_hold #(
  parameter int unsigned     FW      = 3,
  parameter logic [FW-1:0]   RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [FW-1:0] febe_in,
  output logic [FW-1:0] febe_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      febe_q <= RST_VAL;
    else if (accept) febe_q <= febe_in;
  end

  // R5: an accepted frame's code appears on the next cycle
  p_febe_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (febe_q == $past(febe_in)));

  // R8: the code is held between accepted frames
  p_febe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(febe_q));

endmodule

// File: rtl/cbit_fmt_qual.sv
module cbit_fmt_qual
  import cbq_pkg::*;
#(
  parameter int unsigned RUN_LIM   = 63,
  parameter int unsigned WIN       = 15,
  parameter int unsigned CLR_ZEROS = 2,
  parameter int unsigned FEBE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stb,
  input  logic              in_sync,
  input  logic              aic_in,
  input  logic [FEBE_W-1:0] febe_in,
  output logic              fmt_cbit,
  output logic [FEBE_W-1:0] febe_stat,
  output logic              fmt_chg
);

  localparam int unsigned RW = $clog2(RUN_LIM + 1);
  localparam int unsigned CW = $clog2(WIN + 1);

  // Named internal events for the checks
  logic          accept;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_next;
  logic [CW-1:0] zeros_now;
  logic [CW-1:0] zeros_next;
  logic          set_evt;
  logic          clr_evt;
  logic          fmt_d;

  assign accept = frm_stb & in_sync;

  cbq_run_counter #(.RUN_LIM(RUN_LIM)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .bit_one  (aic_in),
    .run_q    (run_q),
    .run_next (run_next)
  );

  cbq_zero_window #(.WIN(WIN)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .bit_one    (aic_in),
    .zeros_now  (zeros_now),
    .zeros_next (zeros_next)
  );

  cbq_febe_hold #(.FW(FEBE_W), .RST_VAL({FEBE_W{1'b1}})) u_febe (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .febe_in (febe_in),
    .febe_q  (febe_stat)
  );

  always_comb begin
    set_evt = accept && !fmt_cbit && (int'(run_next) >= RUN_LIM);
    clr_evt = accept &&  fmt_cbit && (int'(zeros_next) >= CLR_ZEROS);
    fmt_d   = fmt_cbit;
    if (set_evt)      fmt_d = 1'b1;
    else if (clr_evt) fmt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_cbit <= 1'b0;
      fmt_chg  <= 1'b0;
    end else begin
      fmt_cbit <= fmt_d;
      fmt_chg  <= (fmt_d != fmt_cbit);
    end
  end

  // R1: the indication rises only with a full run behind it
  p_set_full_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_cbit) |-> (int'(run_q) == RUN_LIM));

  // R3: the indication falls only with enough zeros in the window
  p_clr_zeros_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fmt_cbit) |-> (int'(zeros_now) >= CLR_ZEROS));

  // R7: the pulse marks a real transition
  p_chg_marks_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_chg |-> (fmt_cbit != $past(fmt_cbit)));

  // R7: the pulse never lasts two cycles
  p_chg_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_chg |=> !fmt_chg);

  // R8: no transition without an accepted frame
  p_fmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(fmt_cbit));

endmodule

// File: tb/cbit_fmt_qual_tb.sv
module cbit_fmt_qual_tb;

  logic       clk;
  logic       rst_n;
  logic       frm_stb;
  logic       in_sync;
  logic       aic_in;
  logic [2:0] febe_in;
  logic       fmt_cbit;
  logic [2:0] febe_stat;
  logic       fmt_chg;

  int n_vec;
  int n_bad;
  bit done;

  typedef struct {
    logic       st;
    logic [2:0] fb;
    logic       ch;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference model state
  bit m_hist[$];
  int m_run;
  bit m_st;
  logic [2:0] m_fb;

  cbit_fmt_qual u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_stb   (frm_stb),
    .in_sync   (in_sync),
    .aic_in    (aic_in),
    .febe_in   (febe_in),
    .fmt_cbit  (fmt_cbit),
    .febe_stat (febe_stat),
    .fmt_chg   (fmt_chg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist.delete();
    m_run = 0;
    m_st  = 1'b0;
    m_fb  = 3'b111;
  endtask

  // Driver: predicts, queues, then issues one accepted frame.
  task automatic send(input bit aic, input logic [2:0] fb, input string tag);
    exp_t e;
    int z;
    bit nst;
    if (aic) m_run = (m_run < 63) ? m_run + 1 : 63;
    else     m_run = 0;
    m_hist.push_back(aic);
    if (m_hist.size() > 15) void'(m_hist.pop_front());
    z = 0;
    foreach (m_hist[i]) if (!m_hist[i]) z++;
    nst = m_st;
    if (!m_st && m_run >= 63) nst = 1'b1;
    else if (m_st && z >= 2)  nst = 1'b0;
    e.st  = nst;
    e.fb  = fb;
    e.ch  = (nst != m_st);
    e.tag = tag;
    m_st  = nst;
    m_fb  = fb;
    exp_q.push_back(e);
    @(negedge clk);
    aic_in  = aic;
    febe_in = fb;
    frm_stb = 1'b1;
    @(negedge clk);
    frm_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_n(input int n, input bit aic, input string tag);
    for (int k = 0; k < n; k++) send(aic, 3'(k % 8), tag);
  endtask

  // Monitor: compares each result one cycle after its accepting edge.
  always begin
    exp_t e;
    bit acc;
    @(posedge clk);
    acc = rst_n && frm_stb && in_sync;
    @(negedge clk);
    if (acc) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R6 unexpected frame: actual accepted expected none");
      end else begin
        e = exp_q.pop_front();
        check(e.tag, "fmt_cbit", {2'b0, fmt_cbit}, {2'b0, e.st});
        check("R5", "febe_stat", febe_stat, e.fb);
        check("R7", "fmt_chg", {2'b0, fmt_chg}, {2'b0, e.ch});
      end
    end else if (rst_n) begin
      check("R7", "idle fmt_chg", {2'b0, fmt_chg}, 3'b000);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check("R9", "reset fmt_cbit", {2'b0, fmt_cbit}, 3'b000);
    check("R9", "reset febe_stat", febe_stat, 3'b111);
    check("R9", "reset fmt_chg", {2'b0, fmt_chg}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; frm_stb = 1'b0; in_sync = 1'b1;
    aic_in = 1'b0; febe_in = 3'b000;
    model_reset();
    do_reset();

    // R2: a zero inside the run restarts the count
    send_n(40, 1'b1, "R2");
    send(1'b0, 3'b011, "R2");
    send_n(62, 1'b1, "R2");
    check("R1", "62 ones still low", {2'b0, fmt_cbit}, 3'b000);
    // R1: the 63rd consecutive one sets the indication
    send(1'b1, 3'b111, "R1");
    check("R1", "63 ones set", {2'b0, fmt_cbit}, 3'b001);
    send_n(10, 1'b1, "R2");

    // R3: a lone zero keeps it set; R4: an old zero ages out
    send(1'b0, 3'b011, "R3");
    send_n(15, 1'b1, "R4");
    send(1'b0, 3'b101, "R4");
    check("R4", "aged zero ignored", {2'b0, fmt_cbit}, 3'b001);
    send_n(13, 1'b1, "R3");
    send(1'b0, 3'b011, "R3");
    check("R3", "two zeros clear", {2'b0, fmt_cbit}, 3'b000);

    // R8: strobes while out of sync are dropped
    send_n(63, 1'b1, "R1");
    @(negedge clk);
    in_sync = 1'b0;
    for (int k = 0; k < 4; k++) begin
      aic_in = 1'b0; febe_in = 3'b010; frm_stb = 1'b1;
      @(negedge clk);
      frm_stb = 1'b0;
      @(negedge clk);
    end
    check("R8", "held fmt_cbit", {2'b0, fmt_cbit}, 3'b001);
    check("R8", "held febe_stat", febe_stat, m_fb);
    in_sync = 1'b1;
    send(1'b0, 3'b111, "R8");
    check("R8", "history untouched", {2'b0, fmt_cbit}, 3'b001);
    send(1'b0, 3'b011, "R3");

    // R5: distinct codes pass straight through
    send(1'b1, 3'b000, "R5");
    send(1'b1, 3'b110, "R5");
    send(1'b1, 3'b011, "R5");
    send(1'b1, 3'b111, "R5");

    // R9: reset in the middle of a run
    send_n(30, 1'b1, "R6");
    do_reset();
    send_n(62, 1'b1, "R9");
    check("R9", "run cleared by reset", {2'b0, fmt_cbit}, 3'b000);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++;
      n_bad++;
      $display("FAIL R6 pending results: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule